// File: doc/BRIEF.md
# SDRAM Request Splitter and Address Decoder

This block sits between an application port and a per-bank SDRAM controller. It takes one linear request (start word address, word count, read/write flag and a wrap flag), splits the start address into column, bank and row fields, and hands one or more pieces to the bank controller. How wide the column field is depends on a two-bit run-time setting. The bank and row fields therefore move up or down in the address as that setting changes.

When wrapping is off, no piece may run past the last column of a page. A request that would do so is cut at the page edge. The rest continues at column 0 of the next page, which is the next bank, with a carry into the row. When wrapping is on, the request goes out as a single piece and the bank controller wraps the column inside the page. Both sides use a valid/ack handshake. The upstream request is acknowledged only after its last piece has been taken.

Top module: `sdrq_splitter`

## Requirements
- R1: After synchronous reset, `dn_valid` and `up_ack` are 0.
- R2: `cfg_col_sel` codes 0, 1, 2 and 3 give 8, 9, 10 and 11 column bits. The column is taken from the lowest address bits, and `dn_col` bits above the chosen width are 0.
- R3: `dn_bank` is the 2 address bits directly above the column field.
- R4: `dn_row` is the 12 address bits directly above the bank field. Address bits above the row are ignored.
- R5: A length field value n means n+1 words. This holds for `up_len` and for `dn_len`, so 0 means a single word.
- R6: With `up_wrap`=0, a request that ends inside its starting page produces exactly one piece, carrying the decoded fields and the original length.
- R7: With `up_wrap`=0, a request that crosses a page edge is cut into pieces. The first piece holds page size minus start column words. Each later piece starts at column 0, with {row,bank} one higher than the previous piece (wrapping at the top). Each later piece holds at most one page, and the last piece holds the remainder.
- R8: With `up_wrap`=1, the request produces one piece with the full length, even if it crosses a page edge, and `dn_wrap` is 1.
- R9: While `dn_valid` is 1 and `dn_ack` is 0, `dn_valid` and all `dn_*` fields stay unchanged. A piece is transferred on a clock edge where both are 1.
- R10: `up_ack` is a one-cycle pulse in the cycle after the last piece is transferred, and never earlier.
- R11: The column setting, the write flag and the wrap flag are sampled when the request is accepted. Changing `cfg_col_sel` while pieces are still being issued does not affect that request.
- R12: Every piece carries the write flag of its request on `dn_wr`.
- R13: A non-wrapping request that ends exactly on the last column of a page produces a single piece and no empty extra piece.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_col_sel | input | 2 | Column width code (8 + code bits) |
| up_valid | input | 1 | Upstream request present; held until up_ack |
| up_addr | input | ADDR_W | Start word address |
| up_len | input | LEN_W | Word count minus one |
| up_wr | input | 1 | 1 = write, 0 = read |
| up_wrap | input | 1 | 1 = wrap within page, 0 = split at page edge |
| up_ack | output | 1 | Request fully issued (one-cycle pulse) |
| dn_valid | output | 1 | Piece present for bank controller |
| dn_bank | output | 2 | Bank of the piece |
| dn_row | output | 12 | Row of the piece |
| dn_col | output | 11 | Start column of the piece |
| dn_len | output | LEN_W | Word count of the piece minus one |
| dn_wr | output | 1 | Write flag of the piece |
| dn_wrap | output | 1 | Wrap flag of the piece |
| dn_ack | input | 1 | Bank controller takes the piece |

## Verification
Two situations matter here: the page-edge cut and the end of the request can fall on the same piece, and a bank carry into the row can fall on the same edge as a stalled handshake. The bench provokes the first with requests that end exactly on, and one word past, the last column of a page. It provokes the second with a start in bank 3 near the end of a page, with the bank controller stalling each piece for several cycles. The results are judged by the number of pieces and by comparing each piece's fields with values the bench computes from plain address arithmetic. The bench also checks that the fields stay unchanged during every stall.

// File: rtl/sdrq_pkg.sv
package sdrq_pkg;

    localparam int ROW_W     = 12;
    localparam int BANK_W    = 2;
    localparam int COL_MIN_W = 8;
    localparam int COL_MAX_W = 11;
    localparam int LOC_W     = ROW_W + BANK_W + COL_MAX_W;

    typedef struct packed {
        logic [ROW_W-1:0]     row;
        logic [BANK_W-1:0]    bank;
        logic [COL_MAX_W-1:0] col;
    } sdrq_loc_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DONE  = 2'd2
    } sdrq_state_e;

    function automatic int unsigned col_bits(input logic [1:0] sel);
        return COL_MIN_W + int'(sel);
    endfunction

    function automatic logic [COL_MAX_W:0] page_words(input logic [1:0] sel);
        logic [COL_MAX_W:0] one;
        one = 1;
        return one << col_bits(sel);
    endfunction

endpackage

// File: rtl/sdrq_addr_decode.sv
module sdrq_addr_decode
    import sdrq_pkg::*;
#(
    parameter int ADDR_W = 26
) (
    input  logic [1:0]        sel,
    input  logic [ADDR_W-1:0] addr,
    output sdrq_loc_t         loc
);
    logic [ADDR_W-1:0]    upper;
    logic [COL_MAX_W-1:0] mask;

    always_comb begin
        upper    = addr >> col_bits(sel);
        mask     = COL_MAX_W'(page_words(sel) - 1'b1);
        loc.col  = addr[COL_MAX_W-1:0] & mask;
        loc.bank = upper[BANK_W-1:0];
        loc.row  = upper[BANK_W +: ROW_W];
    end
endmodule

// File: rtl/sdrq_piece_calc.sv
module sdrq_piece_calc
    import sdrq_pkg::*;
#(
    parameter int LEN_W = 9
) (
    input  logic [1:0]           sel,
    input  logic [COL_MAX_W-1:0] col,
    input  logic [LEN_W:0]       remain,
    input  logic                 wrap,
    output logic [LEN_W:0]       piece,
    output logic                 last
);
    localparam int CW = (LEN_W + 1 > COL_MAX_W + 1) ? LEN_W + 1 : COL_MAX_W + 1;

    logic [CW-1:0] left_w;
    logic [CW-1:0] rem_w;

    always_comb begin
        left_w = CW'(page_words(sel)) - CW'(col);
        rem_w  = CW'(remain);
        last   = wrap || (rem_w <= left_w);
        piece  = last ? remain : (LEN_W + 1)'(left_w);
    end
endmodule

// File: rtl/sdrq_split_ctrl.sv
module sdrq_split_ctrl
    import sdrq_pkg::*;
#(
    parameter int LEN_W = 9
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           cfg_col_sel,
    input  logic                 up_valid,
    input  sdrq_loc_t            up_loc,
    input  logic [LEN_W-1:0]     up_len,
    input  logic                 up_wr,
    input  logic                 up_wrap,
    output logic                 up_ack,
    input  logic [LEN_W:0]       piece,
    input  logic                 piece_last,
    output logic [1:0]           sel_q,
    output logic [LEN_W:0]       remain,
    output sdrq_loc_t            cur,
    output logic                 wrap_q,
    output logic                 dn_valid,
    output logic [LEN_W-1:0]     dn_len,
    output logic                 dn_wr,
    input  logic                 dn_ack
);
    localparam int RB_W = ROW_W + BANK_W;

    sdrq_state_e     state;
    logic            wr_q;
    logic [RB_W-1:0] rb_next;

    assign rb_next  = {cur.row, cur.bank} + RB_W'(1);
    assign dn_valid = (state == ST_ISSUE);
    assign dn_len   = LEN_W'(piece - (LEN_W + 1)'(1));
    assign dn_wr    = wr_q;
    assign up_ack   = (state == ST_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cur    <= '0;
            remain <= '0;
            sel_q  <= '0;
            wr_q   <= 1'b0;
            wrap_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (up_valid) begin
                        cur    <= up_loc;
                        remain <= {1'b0, up_len} + (LEN_W + 1)'(1);
                        sel_q  <= cfg_col_sel;
                        wr_q   <= up_wr;
                        wrap_q <= up_wrap;
                        state  <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (dn_ack) begin
                        if (piece_last) begin
                            state <= ST_DONE;
                        end else begin
                            remain   <= remain - piece;
                            cur.col  <= '0;
                            cur.bank <= rb_next[BANK_W-1:0];
                            cur.row  <= rb_next[BANK_W +: ROW_W];
                        end
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R9
    hold_fields_chk: assert property (@(posedge clk) disable iff (rst)
        (dn_valid && !dn_ack) |=> (dn_valid && $stable(cur) && $stable(dn_len) && $stable(dn_wr)));

    // R10
    ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        up_ack |=> !up_ack);

    // R10
    ack_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        up_ack |-> $past(dn_valid && dn_ack));

    // R7
    next_col_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (dn_valid && dn_ack && !piece_last) |=> (dn_valid && cur.col == '0));

    // R7
    page_fit_chk: assert property (@(posedge clk) disable iff (rst)
        (dn_valid && !wrap_q) |-> ((int'(cur.col) + int'(dn_len)) < int'(page_words(sel_q))));

endmodule

// File: rtl/sdrq_splitter.sv
module sdrq_splitter
    import sdrq_pkg::*;
#(
    parameter int ADDR_W = 26,
    parameter int LEN_W  = 9
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           cfg_col_sel,
    input  logic                 up_valid,
    input  logic [ADDR_W-1:0]    up_addr,
    input  logic [LEN_W-1:0]     up_len,
    input  logic                 up_wr,
    input  logic                 up_wrap,
    output logic                 up_ack,
    output logic                 dn_valid,
    output logic [BANK_W-1:0]    dn_bank,
    output logic [ROW_W-1:0]     dn_row,
    output logic [COL_MAX_W-1:0] dn_col,
    output logic [LEN_W-1:0]     dn_len,
    output logic                 dn_wr,
    output logic                 dn_wrap,
    input  logic                 dn_ack
);
    sdrq_loc_t       up_loc;
    sdrq_loc_t       cur;
    logic [1:0]      sel_q;
    logic [LEN_W:0]  remain;
    logic [LEN_W:0]  piece;
    logic            piece_last;
    logic            wrap_q;

    sdrq_addr_decode #(.ADDR_W(ADDR_W)) u_decode (
        .sel  (cfg_col_sel),
        .addr (up_addr),
        .loc  (up_loc)
    );

    sdrq_piece_calc #(.LEN_W(LEN_W)) u_calc (
        .sel    (sel_q),
        .col    (cur.col),
        .remain (remain),
        .wrap   (wrap_q),
        .piece  (piece),
        .last   (piece_last)
    );

    sdrq_split_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .cfg_col_sel (cfg_col_sel),
        .up_valid    (up_valid),
        .up_loc      (up_loc),
        .up_len      (up_len),
        .up_wr       (up_wr),
        .up_wrap     (up_wrap),
        .up_ack      (up_ack),
        .piece       (piece),
        .piece_last  (piece_last),
        .sel_q       (sel_q),
        .remain      (remain),
        .cur         (cur),
        .wrap_q      (wrap_q),
        .dn_valid    (dn_valid),
        .dn_len      (dn_len),
        .dn_wr       (dn_wr),
        .dn_ack      (dn_ack)
    );

    assign dn_bank = cur.bank;
    assign dn_row  = cur.row;
    assign dn_col  = cur.col;
    assign dn_wrap = wrap_q;

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!dn_valid && !up_ack));

endmodule

// File: tb/sdrq_splitter_tb.sv
module sdrq_splitter_tb;
    localparam int ADDR_W = 26;
    localparam int LEN_W  = 9;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [1:0]        cfg_col_sel = '0;
    logic              up_valid = 1'b0;
    logic [ADDR_W-1:0] up_addr = '0;
    logic [LEN_W-1:0]  up_len = '0;
    logic              up_wr = 1'b0;
    logic              up_wrap = 1'b0;
    logic              up_ack;
    logic              dn_valid;
    logic [1:0]        dn_bank;
    logic [11:0]       dn_row;
    logic [10:0]       dn_col;
    logic [LEN_W-1:0]  dn_len;
    logic              dn_wr;
    logic              dn_wrap;
    logic              dn_ack = 1'b0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    sdrq_splitter #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_dut (
        .clk(clk), .rst(rst), .cfg_col_sel(cfg_col_sel),
        .up_valid(up_valid), .up_addr(up_addr), .up_len(up_len),
        .up_wr(up_wr), .up_wrap(up_wrap), .up_ack(up_ack),
        .dn_valid(dn_valid), .dn_bank(dn_bank), .dn_row(dn_row),
        .dn_col(dn_col), .dn_len(dn_len), .dn_wr(dn_wr),
        .dn_wrap(dn_wrap), .dn_ack(dn_ack)
    );

    always #5 clk = ~clk;

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 50000) begin
                errors++;
                $display("FAIL watchdog: act %0d cycles exp below 50000", cycles);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: act %0d exp %0d", tag, act, exp);
        end
    endtask

    // one request end to end; expected pieces come from plain address arithmetic
    task automatic run_req(input string tag, input int sel, input longint addr, input int len,
                           input bit wr, input bit wrap, input int stall, input int mid_sel);
        longint p_words, span, cur;
        int     remain, n_exp, n_got, waited, gap;
        int     e_col[8], e_bank[8], e_row[8], e_len[8];
        int     g_col[8], g_bank[8], g_row[8], g_len[8];
        bit     g_wr[8], g_wrap[8];
        int     s_col, s_bank, s_row, s_len;
        bit     seen_ack;

        p_words = longint'(1) << (8 + sel);
        span    = p_words * 4 * 4096;
        cur     = addr % span;
        remain  = len + 1;
        n_exp   = 0;
        while (remain > 0 && n_exp < 8) begin
            int pc;
            int left;
            left = int'(p_words - (cur % p_words));
            pc   = (wrap || remain <= left) ? remain : left;
            e_col[n_exp]  = int'(cur % p_words);
            e_bank[n_exp] = int'((cur / p_words) % 4);
            e_row[n_exp]  = int'((cur / (p_words * 4)) % 4096);
            e_len[n_exp]  = pc - 1;
            n_exp++;
            remain -= pc;
            cur = (cur + pc) % span;
        end

        @(negedge clk);
        cfg_col_sel = 2'(sel);
        up_addr  = ADDR_W'(addr);
        up_len   = LEN_W'(len);
        up_wr    = wr;
        up_wrap  = wrap;
        up_valid = 1'b1;
        dn_ack   = 1'b0;
        n_got = 0; waited = 0; gap = 0; seen_ack = 0;
        s_col = 0; s_bank = 0; s_row = 0; s_len = 0;

        for (int t = 0; t < 4000 && !seen_ack; t++) begin
            @(negedge clk);
            gap++;
            if (up_ack) begin
                seen_ack = 1;
                // R10: pulse one cycle after last transfer
                chk(gap == 1, {tag, " R10 ack delay"}, gap, 1);
                up_valid = 1'b0;
                dn_ack   = 1'b0;
            end else if (dn_valid) begin
                if (waited > 0) begin
                    // R9: fields held during stall
                    chk(int'(dn_col) == s_col && int'(dn_bank) == s_bank &&
                        int'(dn_row) == s_row && int'(dn_len) == s_len,
                        {tag, " R9 hold"}, dn_col, s_col);
                end else begin
                    s_col = int'(dn_col); s_bank = int'(dn_bank);
                    s_row = int'(dn_row); s_len = int'(dn_len);
                end
                if (waited >= stall) begin
                    if (n_got < 8) begin
                        g_col[n_got] = int'(dn_col); g_bank[n_got] = int'(dn_bank);
                        g_row[n_got] = int'(dn_row); g_len[n_got] = int'(dn_len);
                        g_wr[n_got] = dn_wr; g_wrap[n_got] = dn_wrap;
                    end
                    n_got++;
                    dn_ack = 1'b1;
                    waited = 0;
                    gap = 0;
                    if (mid_sel >= 0) cfg_col_sel = 2'(mid_sel);
                end else begin
                    dn_ack = 1'b0;
                    waited++;
                end
            end else begin
                dn_ack = 1'b0;
            end
        end

        chk(seen_ack, {tag, " R10 ack seen"}, seen_ack, 1);
        chk(n_got == n_exp, {tag, " R7 piece count"}, n_got, n_exp);
        for (int i = 0; i < n_exp && i < n_got; i++) begin
            chk(g_col[i] == e_col[i], {tag, " R2 col"}, g_col[i], e_col[i]);
            chk(g_bank[i] == e_bank[i], {tag, " R3 bank"}, g_bank[i], e_bank[i]);
            chk(g_row[i] == e_row[i], {tag, " R4 row"}, g_row[i], e_row[i]);
            chk(g_len[i] == e_len[i], {tag, " R5 len"}, g_len[i], e_len[i]);
            chk(g_wr[i] == wr, {tag, " R12 wr"}, g_wr[i], wr);
            chk(g_wrap[i] == wrap, {tag, " R8 wrap flag"}, g_wrap[i], wrap);
        end

        @(negedge clk);
        // R10: single-cycle pulse, block idle afterwards
        chk(!up_ack && !dn_valid, {tag, " R10 pulse end"}, up_ack, 0);
        cfg_col_sel = 2'(sel);
    endtask

    task automatic t_reset();
        // R1
        chk(!dn_valid, "R1 dn_valid after reset", dn_valid, 0);
        chk(!up_ack, "R1 up_ack after reset", up_ack, 0);
    endtask

    task automatic t_fit_narrow();
        // R2 R3 R4 R6: 8 column bits, top address bit set and ignored
        run_req("fit8", 0, (longint'(1) << 25) | (longint'(12'hA5C) << 10) | (2 << 8) | 8'h30,
                3, 0, 0, 0, -1);
    endtask

    task automatic t_fit_wide();
        // R2 R12 R6: 11 column bits, write
        run_req("fit11", 3, (longint'(12'h3C1) << 13) | (1 << 11) | 11'h455, 100, 1, 0, 0, -1);
    endtask

    task automatic t_single_word();
        // R5: length 0 is one word
        run_req("one", 1, 26'h12345, 0, 0, 0, 0, -1);
    endtask

    task automatic t_cross_carry();
        // R7: bank 3 near page end, carry into row, three pieces
        run_req("carry", 0, (longint'(12'h0FF) << 10) | (3 << 8) | 250, 511, 1, 0, 0, -1);
    endtask

    task automatic t_cross_top();
        // R7: top of address space wraps to row 0 bank 0
        run_req("top", 1, (longint'(12'hFFF) << 11) | (3 << 9) | 500, 40, 0, 0, 0, -1);
    endtask

    task automatic t_wrap();
        // R8: crossing request stays whole when wrap is set
        run_req("wrap", 0, (longint'(5) << 10) | (1 << 8) | 200, 300, 0, 1, 0, -1);
    endtask

    task automatic t_exact_end();
        // R13: ends on last column, then one word past it
        run_req("exact", 2, (longint'(7) << 12) | (2 << 10) | 1000, 23, 0, 0, 0, -1);
        run_req("exact+1", 2, (longint'(7) << 12) | (2 << 10) | 1000, 24, 0, 0, 0, -1);
    endtask

    task automatic t_stall();
        // R9 R7: stalled handshakes across a bank carry
        run_req("stall", 0, (longint'(9) << 10) | (3 << 8) | 240, 300, 1, 0, 3, -1);
    endtask

    task automatic t_mid_cfg();
        // R11: column setting changed after first piece is ignored
        run_req("midcfg", 0, (longint'(4) << 10) | (1 << 8) | 200, 400, 0, 0, 1, 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_fit_narrow();
        t_fit_wide();
        t_single_word();
        t_cross_carry();
        t_cross_top();
        t_wrap();
        t_exact_end();
        t_stall();
        t_mid_cfg();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule